// File: doc/BRIEF.md
# Full-Frame CCD Clock Sequencer

This block produces the digital clock pattern that drives a full-frame CCD with a single output amplifier. It generates the two vertical transfer phases, the two serial register phases and the reset gate. It also generates a clamp strobe and a sample strobe for an external converter. Level shifting, analog bias and the converter itself are handled elsewhere. All timing is counted in system clock cycles, and parameters set the pixel period, the vertical pulse width, the phase overlap, the setup gap and the strobe positions.

A pulse on the start input latches the exposure length and begins a frame. The frame starts with an integration period in which both vertical phases stay low. Readout then follows, one line at a time. Each line has three parts:

1. A vertical handoff: phase 1, then phase 2, with a short overlap. The serial register receives the row when phase 2 falls, while serial phase 1 is held high.
2. A quiet setup gap.
3. Complementary serial shifting of every pixel of the line.

The reset gate pulses at the start of every pixel period, in every state. The states are IDLE, INTEG, VXFER, SETUP and SHIFT. The transitions are:

- start (IDLE to INTEG)
- exposure done (INTEG to VXFER)
- transfer done (VXFER to SETUP)
- gap done (SETUP to SHIFT)
- line done, more lines (SHIFT to VXFER)
- frame done (SHIFT to IDLE)

Top module: `ccd_frame_seq`

## Requirements
- R1: After reset and while idle, busy, line-valid and pixel-valid are low, both vertical phases are low, serial phase 1 is high and serial phase 2 is low.
- R2: A start pulse that arrives while busy is high is ignored: the running frame keeps its exposure length and its end cycle.
- R3: The first busy cycle is the cycle after the start pulse is sampled. Integration lasts exposure+1 cycles, with both vertical phases low.
- R4: The vertical transfer lasts 2*VPW_CYC cycles, counted as t = 0 and upward. Phase 1 is high for t < VPW_CYC+OVL_CYC and phase 2 is high for t >= VPW_CYC, so at least one phase is high throughout. Serial phase 1 stays high.
- R5: The setup gap lasts SETUP_CYC cycles. Both vertical phases are low, serial phase 1 is high and line-valid is low.
- R6: During shifting, line-valid is high for exactly PIX_CYC*PIX_PER_LINE cycles. Within each pixel period (phase p = 0..PIX_CYC-1), serial phase 1 is high for p < PIX_CYC/2 and serial phase 2 is its complement.
- R7: The reset gate is high for phase p < RG_CYC of every pixel period, and it keeps running during transfer and setup. The phase restarts at 0 on the first shifting cycle.
- R8: During shifting, the clamp strobe fires at p == CLMP_OFS and the sample strobe at p == SAMP_OFS. Pixel-valid fires at p == PIX_CYC-1. None of them fires outside shifting.
- R9: Each line takes 2*VPW_CYC + SETUP_CYC + PIX_CYC*PIX_PER_LINE cycles. After LINES lines the block returns to idle, so a frame is busy for exposure+1 plus LINES times the line time.
- R10: Serial phase 1 is high in the cycle in which vertical phase 2 falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start request, sampled when idle |
| exp_len_i | input | EXP_W | Exposure length in cycles (integration lasts this plus one) |
| busy_o | output | 1 | Frame in progress |
| line_valid_o | output | 1 | Serial shifting of a line in progress |
| pix_valid_o | output | 1 | One-cycle pulse at the end of each shifted pixel |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| h1_o | output | 1 | Serial phase 1 |
| h2_o | output | 1 | Serial phase 2 |
| rg_o | output | 1 | Reset gate pulse |
| samp_o | output | 1 | Converter sample strobe |
| clmp_o | output | 1 | Converter clamp strobe |

## Verification
The hardest case to reach from the ports is a start request that lands deep inside a running frame, in each of its phases, with an exposure different from the latched one. The stimulus sweeps every exposure value of a 4-bit configuration. In alternate frames it injects a second start at a cycle offset that moves through integration, transfer, setup and shifting. A further difficulty is the reset-gate phase across the realignment at each shift start. The bench predicts this phase arithmetically for every transfer and setup cycle after the first line, and checks it there.

// File: rtl/ccd_frame_pkg.sv
`timescale 1ns/1ps
package ccd_frame_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INTEG = 3'd1,
        ST_VXFER = 3'd2,
        ST_SETUP = 3'd3,
        ST_SHIFT = 3'd4
    } seq_state_t;
endpackage

// File: rtl/ccd_pix_timer.sv
`timescale 1ns/1ps
// Free-running pixel phase counter: reset gate, serial phases and strobes.
module ccd_pix_timer #(
    parameter int PIX_CYC  = 50,
    parameter int RG_CYC   = 2,
    parameter int SAMP_OFS = 36,
    parameter int CLMP_OFS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic realign_i,
    input  logic shift_i,
    output logic wrap_o,
    output logic rg_o,
    output logic h1_o,
    output logic h2_o,
    output logic samp_o,
    output logic clmp_o,
    output logic pixv_o
);
    localparam int PH_W = (PIX_CYC > 1) ? $clog2(PIX_CYC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PIX_CYC - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(PIX_CYC / 2);
    localparam logic [PH_W-1:0] PH_RG   = PH_W'(RG_CYC);
    localparam logic [PH_W-1:0] PH_SAMP = PH_W'(SAMP_OFS);
    localparam logic [PH_W-1:0] PH_CLMP = PH_W'(CLMP_OFS);

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              ph <= '0;
        else if (realign_i)      ph <= '0;
        else if (ph == PH_LAST)  ph <= '0;
        else                     ph <= ph + 1'b1;
    end

    always_comb begin
        wrap_o = (ph == PH_LAST);
        rg_o   = (ph < PH_RG);
        h1_o   = !shift_i || (ph < PH_HALF);
        h2_o   = shift_i && !(ph < PH_HALF);
        samp_o = shift_i && (ph == PH_SAMP);
        clmp_o = shift_i && (ph == PH_CLMP);
        pixv_o = shift_i && (ph == PH_LAST);
    end

    // R7: a new pixel period always opens with the reset gate high
    a_r7_rg_opens_period: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !realign_i) |=> rg_o);
    // R8: converter strobes only while shifting
    a_r8_strobe_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_o || clmp_o || pixv_o) |-> shift_i);
endmodule

// File: rtl/ccd_vert_gen.sv
`timescale 1ns/1ps
// Vertical phase pair with overlap, decoded from the transfer counter.
module ccd_vert_gen #(
    parameter int VPW_CYC = 4000,
    parameter int OVL_CYC = 4,
    parameter int CW      = 13
) (
    input  logic          active_i,
    input  logic [CW-1:0] t_i,
    output logic          v1_o,
    output logic          v2_o
);
    localparam logic [CW-1:0] V1_END = CW'(VPW_CYC + OVL_CYC);
    localparam logic [CW-1:0] V2_BEG = CW'(VPW_CYC);

    always_comb begin
        v1_o = active_i && (t_i < V1_END);
        v2_o = active_i && (t_i >= V2_BEG);
    end
endmodule

// File: rtl/ccd_frame_seq.sv
`timescale 1ns/1ps
module ccd_frame_seq
    import ccd_frame_pkg::*;
#(
    parameter int PIX_CYC      = 50,
    parameter int PIX_PER_LINE = 3103,
    parameter int LINES        = 3086,
    parameter int VPW_CYC      = 4000,
    parameter int OVL_CYC      = 4,
    parameter int SETUP_CYC    = 1600,
    parameter int RG_CYC       = 2,
    parameter int SAMP_OFS     = 36,
    parameter int CLMP_OFS     = 8,
    parameter int EXP_W        = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [EXP_W-1:0] exp_len_i,
    output logic             busy_o,
    output logic             line_valid_o,
    output logic             pix_valid_o,
    output logic             v1_o,
    output logic             v2_o,
    output logic             h1_o,
    output logic             h2_o,
    output logic             rg_o,
    output logic             samp_o,
    output logic             clmp_o
);
    localparam int XW    = $clog2(2 * VPW_CYC + 1);
    localparam int SW    = $clog2(SETUP_CYC + 1);
    localparam int M1    = (XW > SW) ? XW : SW;
    localparam int CNT_W = (M1 > EXP_W) ? M1 : EXP_W;
    localparam int PXW   = (PIX_PER_LINE > 1) ? $clog2(PIX_PER_LINE) : 1;
    localparam int LNW   = (LINES > 1) ? $clog2(LINES) : 1;
    localparam logic [CNT_W-1:0] XFER_LAST = CNT_W'(2 * VPW_CYC - 1);
    localparam logic [CNT_W-1:0] SET_LAST  = CNT_W'(SETUP_CYC - 1);
    localparam logic [PXW-1:0]   PX_LAST   = PXW'(PIX_PER_LINE - 1);
    localparam logic [LNW-1:0]   LN_LAST   = LNW'(LINES - 1);

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [EXP_W-1:0] exp_q;
    logic [PXW-1:0]   pix_idx;
    logic [LNW-1:0]   line_idx;
    logic             wrap, realign, shifting, xfer, line_end;

    assign shifting = (state == ST_SHIFT);
    assign xfer     = (state == ST_VXFER);
    assign line_end = shifting && wrap && (pix_idx == PX_LAST);
    assign realign  = (state == ST_SETUP) && (nxt == ST_SHIFT);

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_i)                        nxt = ST_INTEG;
            ST_INTEG: if (cnt == CNT_W'(exp_q))           nxt = ST_VXFER;
            ST_VXFER: if (cnt == XFER_LAST)               nxt = ST_SETUP;
            ST_SETUP: if (cnt == SET_LAST)                nxt = ST_SHIFT;
            ST_SHIFT: if (line_end) nxt = (line_idx == LN_LAST) ? ST_IDLE : ST_VXFER;
            default:                                      nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // duration, pixel and line counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            exp_q    <= '0;
            pix_idx  <= '0;
            line_idx <= '0;
        end else begin
            cnt <= (nxt != state) ? '0 : cnt + 1'b1;
            if (state == ST_IDLE && start_i) begin
                exp_q    <= exp_len_i;
                line_idx <= '0;
            end
            if (realign)
                pix_idx <= '0;
            else if (shifting && wrap)
                pix_idx <= (pix_idx == PX_LAST) ? '0 : pix_idx + 1'b1;
            if (line_end && line_idx != LN_LAST)
                line_idx <= line_idx + 1'b1;
        end
    end

    // state-decoded outputs
    always_comb begin
        busy_o       = (state != ST_IDLE);
        line_valid_o = shifting;
    end

    ccd_vert_gen #(
        .VPW_CYC (VPW_CYC),
        .OVL_CYC (OVL_CYC),
        .CW      (CNT_W)
    ) u_vert (
        .active_i (xfer),
        .t_i      (cnt),
        .v1_o     (v1_o),
        .v2_o     (v2_o)
    );

    ccd_pix_timer #(
        .PIX_CYC  (PIX_CYC),
        .RG_CYC   (RG_CYC),
        .SAMP_OFS (SAMP_OFS),
        .CLMP_OFS (CLMP_OFS)
    ) u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .realign_i (realign),
        .shift_i   (shifting),
        .wrap_o    (wrap),
        .rg_o      (rg_o),
        .h1_o      (h1_o),
        .h2_o      (h2_o),
        .samp_o    (samp_o),
        .clmp_o    (clmp_o),
        .pixv_o    (pix_valid_o)
    );

    // R2: a start while busy leaves the latched exposure untouched
    a_r2_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start_i) |=> $stable(exp_q));
    // R3: vertical phases quiet while integrating
    a_r3_integ_vlow: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTEG) |-> (!v1_o && !v2_o));
    // R4: no gap between the overlapping vertical phases
    a_r4_vphase_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && $past(xfer)) |-> (v1_o || v2_o));
    // R5: setup gap is quiet with serial phase 1 held
    a_r5_setup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP) |-> (!v1_o && !v2_o && h1_o && !line_valid_o));
    // R9: line index stays within the frame
    a_r9_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
        line_idx <= LN_LAST);
    // R10: serial phase 1 high when the row drops into the serial register
    a_r10_h1_on_v2_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(v2_o) |-> h1_o);
endmodule

// File: tb/ccd_frame_seq_tb.sv
`timescale 1ns/1ps
module ccd_frame_seq_tb;
    localparam int PIX   = 6;
    localparam int NPIX  = 4;
    localparam int NLN   = 3;
    localparam int VPW   = 5;
    localparam int OVL   = 2;
    localparam int SETC  = 3;
    localparam int RGC   = 2;
    localparam int SAMP  = 4;
    localparam int CLMP  = 2;
    localparam int EW    = 4;
    localparam int LT    = 2 * VPW + SETC + PIX * NPIX;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [EW-1:0] exp_len = '0;
    logic busy, lv, pv, v1, v2, h1, h2, rg, samp, clmp;
    int total = 0;
    int bad = 0;
    bit prev_v2 = 1'b0;

    always #2.5 clk = ~clk;

    ccd_frame_seq #(
        .PIX_CYC(PIX), .PIX_PER_LINE(NPIX), .LINES(NLN), .VPW_CYC(VPW),
        .OVL_CYC(OVL), .SETUP_CYC(SETC), .RG_CYC(RGC), .SAMP_OFS(SAMP),
        .CLMP_OFS(CLMP), .EXP_W(EW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .exp_len_i(exp_len),
        .busy_o(busy), .line_valid_o(lv), .pix_valid_o(pv), .v1_o(v1), .v2_o(v2),
        .h1_o(h1), .h2_o(h2), .rg_o(rg), .samp_o(samp), .clmp_o(clmp)
    );

    task automatic chk(input string req, input string sig, input logic act, input logic expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, sig, act, expv, $time);
        end
    endtask

    task automatic idle_checks(input string req);
        chk(req, "busy", busy, 1'b0);
        chk(req, "line_valid", lv, 1'b0);
        chk(req, "pix_valid", pv, 1'b0);
        chk(req, "v1", v1, 1'b0);
        chk(req, "v2", v2, 1'b0);
        chk(req, "h1", h1, 1'b1);
        chk(req, "h2", h2, 1'b0);
    endtask

    // expected outputs for cycle k of a frame with exposure e
    task automatic check_at(input int k, input int e);
        int fr, j, ln, r, s, ph;
        logic eb, ev1, ev2, eh1, eh2, elv, epv, esp, ecp, erg;
        bit rgk;
        string vtag;
        fr = e + 1 + NLN * LT;
        eb = 0; ev1 = 0; ev2 = 0; eh1 = 1; eh2 = 0; elv = 0; epv = 0; esp = 0; ecp = 0;
        erg = 0; rgk = 0; vtag = "R9";
        if (k < fr) begin
            eb = 1;
            if (k <= e) vtag = "R3";
            else begin
                j = k - e - 1; ln = j / LT; r = j % LT;
                if (r < 2 * VPW) begin
                    vtag = "R4"; ev1 = (r < VPW + OVL); ev2 = (r >= VPW);
                    rgk = (ln > 0); erg = ((r % PIX) < RGC);
                end else if (r < 2 * VPW + SETC) begin
                    vtag = "R5"; rgk = (ln > 0); erg = ((r % PIX) < RGC);
                end else begin
                    vtag = "R6"; s = r - 2 * VPW - SETC; ph = s % PIX;
                    eh1 = (ph < PIX / 2); eh2 = !eh1; elv = 1;
                    epv = (ph == PIX - 1); esp = (ph == SAMP); ecp = (ph == CLMP);
                    rgk = 1; erg = (ph < RGC);
                end
            end
        end
        chk("R9", "busy", busy, eb);
        chk(vtag, "v1", v1, ev1);
        chk(vtag, "v2", v2, ev2);
        chk("R6", "h1", h1, eh1);
        chk("R6", "h2", h2, eh2);
        chk("R6", "line_valid", lv, elv);
        chk("R8", "pix_valid", pv, epv);
        chk("R8", "samp", samp, esp);
        chk("R8", "clmp", clmp, ecp);
        if (rgk) chk("R7", "rg", rg, erg);
        if (prev_v2 && !v2) chk("R10", "h1_at_v2_fall", h1, 1'b1);
        prev_v2 = v2;
    endtask

    task automatic run_frame(input int e, input int inj_k, input int inj_e);
        int fr, npv;
        fr = e + 1 + NLN * LT;
        npv = 0;
        @(negedge clk);
        exp_len = EW'(e); start = 1'b1;
        @(negedge clk);
        start = 1'b0; exp_len = EW'(inj_e);
        for (int k = 0; k < fr + 4; k++) begin
            check_at(k, e);
            if (pv) npv++;
            if (inj_k >= 0) begin
                if (k == fr - 1) chk("R2", "busy_before_end", busy, 1'b1);
                if (k == fr)     chk("R2", "busy_at_end", busy, 1'b0);
            end
            start = (k == inj_k);
            @(negedge clk);
        end
        chk("R9", "pixels_per_frame", (npv == NLN * NPIX), 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        idle_checks("R1");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        idle_checks("R1");
        for (int e = 0; e < (1 << EW); e++) begin
            if (e % 2 == 1) run_frame(e, (e * 13) % (e + NLN * LT - 1), (1 << EW) - 1 - e);
            else            run_frame(e, -1, 0);
            idle_checks("R1");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule